// File: doc/BRIEF.md
# Interrupt Controller Initialization Sequencer

This block decodes byte-wide I/O writes aimed at one interrupt controller and runs its initialization protocol. The controller owns two adjacent addresses: a command address (the parameterised base, 020h by default, with a second instance typically placed at 0A0h) and a data address one above it. A command-address write whose bit 4 is high opens initialization. The block then steers the next three data-address writes, in a fixed order, into the vector-base register, the cascade register and the mode register. After the third of these it reports itself ready, and data-address writes from then on load the interrupt mask.

Command-address writes with bit 4 low are operational command words. The block hands them on to the rest of the controller without touching the initialization progress. Opening initialization also clears the mask and sends a one-cycle pulse that tells the priority and in-service logic to reset. The captured settings are outputs, and so is the full interrupt vector, which joins the stored vector base to the level number being acknowledged.

Top module: `irq_init_seqr`

## Requirements
- R1: After reset, ready, irq_mask, level_trig, single_mode, vec_base, casc_cfg, mode_flags, init_clr and ocw_valid are all zero.
- R2: A write to BASE_ADDR with data bit 4 = 1 (init start) makes, in the next cycle, ready = 0, irq_mask = 0, init_clr = 1 for exactly one cycle, level_trig = data bit 3 and single_mode = data bit 1.
- R3: The first write to BASE_ADDR+1 after an init start stores data bits 7..3 in vec_base.
- R4: The second write to BASE_ADDR+1 after an init start stores all eight data bits in casc_cfg.
- R5: The third write to BASE_ADDR+1 after an init start stores data bits 4..0 in mode_flags, and ready is 1 from the next cycle on.
- R6: While initialization is incomplete, or before any init start, writes to BASE_ADDR+1 leave irq_mask unchanged.
- R7: While ready is 1, a write to BASE_ADDR+1 loads irq_mask with the data, visible the next cycle.
- R8: An init start that arrives in the middle of the sequence restarts it, so that the next BASE_ADDR+1 write goes to vec_base again.
- R9: A write to BASE_ADDR with data bit 4 = 0 gives ocw_valid = 1 for one cycle, with ocw_data equal to the written byte, in the next cycle (registered variant). It changes no initialization state, mask or ready.
- R10: Writes to any other address, and cycles with io_wr low, change nothing.
- R11: vec_out is {vec_base, irq_level} at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| io_addr | input | ADDR_W | I/O write address |
| io_wdata | input | 8 | I/O write data |
| irq_level | input | LVL_W | Interrupt level being acknowledged |
| init_clr | output | 1 | One-cycle pulse: reset priority and in-service state |
| level_trig | output | 1 | 1 = level triggered, 0 = edge triggered |
| single_mode | output | 1 | Single-controller flag from the start word |
| vec_base | output | 8-LVL_W | Stored interrupt vector base |
| vec_out | output | 8 | Full interrupt vector |
| casc_cfg | output | 8 | Cascade configuration byte |
| mode_flags | output | MODE_W | Mode flags from the fourth word |
| irq_mask | output | 8 | Interrupt mask register |
| ready | output | 1 | Initialization complete |
| ocw_valid | output | 1 | Operational command word strobe |
| ocw_data | output | 8 | Operational command word byte |

## Verification
A sequencer stuck in the wrong step shows up at the ports on the very next data-address write. The byte then lands in vec_base, casc_cfg, mode_flags or irq_mask when it should have gone to another of them, and ready rises one write early or late. A decode fault on the command address shows within one cycle, either as a missing or spurious init_clr or ocw_valid pulse or as a mask that was not cleared. Random traffic that mixes restarts, command words and foreign addresses is compared against a bench model after every single cycle, so any such fault is reported at the cycle where it occurs.

// File: rtl/irq_init_pkg.sv
package irq_init_pkg;

   typedef enum logic [2:0] {
      SEQ_UNINIT = 3'd0,
      SEQ_W2     = 3'd1,
      SEQ_W3     = 3'd2,
      SEQ_W4     = 3'd3,
      SEQ_RUN    = 3'd4
   } seq_state_t;

   // Decoded class of the current I/O write (all zero when no write hits).
   typedef struct packed {
      logic icw1;   // command address, start bit set
      logic ocw;    // command address, start bit clear
      logic dport;  // data address (base + 1)
   } wr_kind_t;

endpackage

// File: rtl/irq_init_decode.sv
module irq_init_decode
   import irq_init_pkg::*;
#(
   parameter int unsigned ADDR_W    = 16,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0020
) (
   input  logic              io_wr,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              start_bit,
   output wr_kind_t          kind
);
   localparam logic [ADDR_W-1:0] DATA_ADDR = BASE_ADDR + 1'b1;

   logic hit_cmd;
   logic hit_dat;

   always_comb begin
      hit_cmd    = io_wr && (io_addr == BASE_ADDR);
      hit_dat    = io_wr && (io_addr == DATA_ADDR);
      kind.icw1  = hit_cmd &&  start_bit;
      kind.ocw   = hit_cmd && !start_bit;
      kind.dport = hit_dat;
   end
endmodule

// File: rtl/irq_init_fsm.sv
module irq_init_fsm
   import irq_init_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  wr_kind_t kind,
   output logic     ld_w2,
   output logic     ld_w3,
   output logic     ld_w4,
   output logic     ld_mask,
   output logic     ready
);
   seq_state_t state_q;
   seq_state_t state_d;

   always_comb begin
      state_d = state_q;
      if (kind.icw1) begin
         state_d = SEQ_W2;
      end else if (kind.dport) begin
         unique case (state_q)
            SEQ_W2:  state_d = SEQ_W3;
            SEQ_W3:  state_d = SEQ_W4;
            SEQ_W4:  state_d = SEQ_RUN;
            default: state_d = state_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= SEQ_UNINIT;
      else        state_q <= state_d;
   end

   always_comb begin
      ld_w2   = kind.dport && (state_q == SEQ_W2);
      ld_w3   = kind.dport && (state_q == SEQ_W3);
      ld_w4   = kind.dport && (state_q == SEQ_W4);
      ld_mask = kind.dport && (state_q == SEQ_RUN);
      ready   = (state_q == SEQ_RUN);
   end
endmodule

// File: rtl/irq_init_regs.sv
module irq_init_regs #(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned LVL_W    = 3,
   parameter int unsigned MODE_W   = 5,
   parameter int unsigned TRIG_BIT = 3,
   parameter int unsigned SNGL_BIT = 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [DATA_W-1:0]       wdata,
   input  logic                    init_start,
   input  logic                    ld_w2,
   input  logic                    ld_w3,
   input  logic                    ld_w4,
   input  logic                    ld_mask,
   output logic                    init_clr,
   output logic                    level_trig,
   output logic                    single_mode,
   output logic [DATA_W-LVL_W-1:0] vec_base,
   output logic [DATA_W-1:0]       casc_cfg,
   output logic [MODE_W-1:0]       mode_flags,
   output logic [DATA_W-1:0]       irq_mask
);
   localparam int unsigned BASE_W = DATA_W - LVL_W;

   // Word 1 fields plus the clear pulse.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         init_clr    <= 1'b0;
         level_trig  <= 1'b0;
         single_mode <= 1'b0;
      end else begin
         init_clr <= init_start;
         if (init_start) begin
            level_trig  <= wdata[TRIG_BIT];
            single_mode <= wdata[SNGL_BIT];
         end
      end
   end

   // Words 2 to 4.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vec_base   <= '0;
         casc_cfg   <= '0;
         mode_flags <= '0;
      end else begin
         if (ld_w2) vec_base   <= wdata[DATA_W-1 -: BASE_W];
         if (ld_w3) casc_cfg   <= wdata;
         if (ld_w4) mode_flags <= wdata[MODE_W-1:0];
      end
   end

   // Mask: cleared by a start word, loaded only once running.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          irq_mask <= '0;
      else if (init_start) irq_mask <= '0;
      else if (ld_mask)    irq_mask <= wdata;
   end
endmodule

// File: rtl/irq_init_ocw.sv
module irq_init_ocw #(
   parameter int unsigned DATA_W     = 8,
   parameter bit          REGISTERED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ocw_hit,
   input  logic [DATA_W-1:0] wdata,
   output logic              ocw_valid,
   output logic [DATA_W-1:0] ocw_data
);
   generate
      if (REGISTERED) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ocw_valid <= 1'b0;
               ocw_data  <= '0;
            end else begin
               ocw_valid <= ocw_hit;
               if (ocw_hit) ocw_data <= wdata;
            end
         end
      end else begin : g_comb
         always_comb begin
            ocw_valid = ocw_hit;
            ocw_data  = wdata;
         end
      end
   endgenerate
endmodule

// File: rtl/irq_init_seqr.sv
module irq_init_seqr
   import irq_init_pkg::*;
#(
   parameter int unsigned       ADDR_W        = 16,
   parameter logic [ADDR_W-1:0] BASE_ADDR     = 16'h0020,
   parameter int unsigned       LVL_W         = 3,
   parameter int unsigned       MODE_W        = 5,
   parameter bit                OCW_REGISTERED = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                io_wr,
   input  logic [ADDR_W-1:0]   io_addr,
   input  logic [7:0]          io_wdata,
   input  logic [LVL_W-1:0]    irq_level,
   output logic                init_clr,
   output logic                level_trig,
   output logic                single_mode,
   output logic [7-LVL_W:0]    vec_base,
   output logic [7:0]          vec_out,
   output logic [7:0]          casc_cfg,
   output logic [MODE_W-1:0]   mode_flags,
   output logic [7:0]          irq_mask,
   output logic                ready,
   output logic                ocw_valid,
   output logic [7:0]          ocw_data
);
   localparam int unsigned DATA_W    = 8;
   localparam int unsigned START_BIT = 4;
   localparam int unsigned TRIG_BIT  = 3;
   localparam int unsigned SNGL_BIT  = 1;

   initial begin : elab_checks
      assert (LVL_W >= 1 && LVL_W < DATA_W)
         else $fatal(1, "LVL_W must be between 1 and 7");
      assert (MODE_W >= 1 && MODE_W <= DATA_W)
         else $fatal(1, "MODE_W must be between 1 and 8");
      assert (BASE_ADDR[0] == 1'b0)
         else $fatal(1, "BASE_ADDR must be even");
   end

   wr_kind_t kind;
   logic     ld_w2, ld_w3, ld_w4, ld_mask;

   irq_init_decode #(
      .ADDR_W    (ADDR_W),
      .BASE_ADDR (BASE_ADDR)
   ) decode_i (
      .io_wr     (io_wr),
      .io_addr   (io_addr),
      .start_bit (io_wdata[START_BIT]),
      .kind      (kind)
   );

   irq_init_fsm fsm_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .kind    (kind),
      .ld_w2   (ld_w2),
      .ld_w3   (ld_w3),
      .ld_w4   (ld_w4),
      .ld_mask (ld_mask),
      .ready   (ready)
   );

   irq_init_regs #(
      .DATA_W   (DATA_W),
      .LVL_W    (LVL_W),
      .MODE_W   (MODE_W),
      .TRIG_BIT (TRIG_BIT),
      .SNGL_BIT (SNGL_BIT)
   ) regs_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .wdata       (io_wdata),
      .init_start  (kind.icw1),
      .ld_w2       (ld_w2),
      .ld_w3       (ld_w3),
      .ld_w4       (ld_w4),
      .ld_mask     (ld_mask),
      .init_clr    (init_clr),
      .level_trig  (level_trig),
      .single_mode (single_mode),
      .vec_base    (vec_base),
      .casc_cfg    (casc_cfg),
      .mode_flags  (mode_flags),
      .irq_mask    (irq_mask)
   );

   irq_init_ocw #(
      .DATA_W     (DATA_W),
      .REGISTERED (OCW_REGISTERED)
   ) ocw_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .ocw_hit   (kind.ocw),
      .wdata     (io_wdata),
      .ocw_valid (ocw_valid),
      .ocw_data  (ocw_data)
   );

   assign vec_out = {vec_base, irq_level};
endmodule

// File: rtl/irq_init_seqr_chk.sv
module irq_init_seqr_chk #(
   parameter int unsigned       ADDR_W         = 16,
   parameter logic [ADDR_W-1:0] BASE_ADDR      = 16'h0020,
   parameter int unsigned       LVL_W          = 3,
   parameter int unsigned       MODE_W         = 5,
   parameter bit                OCW_REGISTERED = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              io_wr,
   input logic [ADDR_W-1:0] io_addr,
   input logic [7:0]        io_wdata,
   input logic              init_clr,
   input logic [7-LVL_W:0]  vec_base,
   input logic [7:0]        casc_cfg,
   input logic [MODE_W-1:0] mode_flags,
   input logic [7:0]        irq_mask,
   input logic              ready,
   input logic              ocw_valid,
   input logic [7:0]        ocw_data
);
   localparam logic [ADDR_W-1:0] DATA_ADDR = BASE_ADDR + 1'b1;

   logic cmd_hit, dat_hit, other;
   assign cmd_hit = io_wr && (io_addr == BASE_ADDR);
   assign dat_hit = io_wr && (io_addr == DATA_ADDR);
   assign other   = !cmd_hit && !dat_hit;

   // R2: start word drops ready, clears mask and pulses init_clr.
   a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_hit && io_wdata[4]) |=> (!ready && irq_mask == 8'h00 && init_clr));

   // R2: init_clr is a single-cycle pulse.
   a_r2_clr_single: assert property (@(posedge clk) disable iff (!rst_n)
      (init_clr && !$past(cmd_hit && io_wdata[4])) |-> 1'b0);

   // R5: ready only rises after a data-address write.
   a_r5_ready_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> $past(dat_hit));

   // R6 / R7: mask moves only through a running data write or a start word.
   a_r7_mask_source: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(irq_mask) |-> ($past(dat_hit && ready) || $past(cmd_hit && io_wdata[4])));

   // R9: command word is forwarded and leaves sequence state untouched.
   a_r9_ocw_forward: assert property (@(posedge clk) disable iff (!rst_n)
      (OCW_REGISTERED && cmd_hit && !io_wdata[4]) |=>
         (ocw_valid && ocw_data == $past(io_wdata) && $stable(ready) && $stable(irq_mask)));

   // R9: the two pulses never coincide in the registered variant.
   a_r9_pulses_apart: assert property (@(posedge clk) disable iff (!rst_n)
      OCW_REGISTERED |-> $onehot0({init_clr, ocw_valid}));

   // R10: foreign or idle cycles change no state.
   a_r10_foreign_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      other |=> ($stable(ready) && $stable(irq_mask) && $stable(vec_base)
                 && $stable(casc_cfg) && $stable(mode_flags) && !init_clr));
endmodule

bind irq_init_seqr irq_init_seqr_chk #(
   .ADDR_W         (ADDR_W),
   .BASE_ADDR      (BASE_ADDR),
   .LVL_W          (LVL_W),
   .MODE_W         (MODE_W),
   .OCW_REGISTERED (OCW_REGISTERED)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .io_wr      (io_wr),
   .io_addr    (io_addr),
   .io_wdata   (io_wdata),
   .init_clr   (init_clr),
   .vec_base   (vec_base),
   .casc_cfg   (casc_cfg),
   .mode_flags (mode_flags),
   .irq_mask   (irq_mask),
   .ready      (ready),
   .ocw_valid  (ocw_valid),
   .ocw_data   (ocw_data)
);

// File: tb/irq_init_seqr_tb_top.sv
`timescale 1ns/1ps
module irq_init_seqr_tb_top;
   localparam logic [15:0] BASE = 16'h0020;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        io_wr = 1'b0;
   logic [15:0] io_addr = '0;
   logic [7:0]  io_wdata = '0;
   logic [2:0]  irq_level = '0;
   logic        init_clr, level_trig, single_mode, ready, ocw_valid;
   logic [4:0]  vec_base, mode_flags;
   logic [7:0]  vec_out, casc_cfg, irq_mask, ocw_data;

   always #2 clk = ~clk;

   irq_init_seqr dut_i (
      .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
      .io_wdata(io_wdata), .irq_level(irq_level), .init_clr(init_clr),
      .level_trig(level_trig), .single_mode(single_mode), .vec_base(vec_base),
      .vec_out(vec_out), .casc_cfg(casc_cfg), .mode_flags(mode_flags),
      .irq_mask(irq_mask), .ready(ready), .ocw_valid(ocw_valid), .ocw_data(ocw_data)
   );

   int n_chk = 0;
   int n_bad = 0;

   // Model: 0 uninit, 1..3 waiting for word 2..4, 4 running.
   int       m_st = 0;
   bit [7:0] m_mask = 0, m_casc = 0, m_ocwd = 0;
   bit [4:0] m_vb = 0, m_mode = 0;
   bit       m_lt = 0, m_sm = 0, m_clr = 0, m_ocwv = 0;

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic bit [7:0] exp_vec(bit [4:0] vb, bit [2:0] lvl);
      return {vb, lvl};
   endfunction

   task automatic check_all();
      chk("R2 init_clr", init_clr, m_clr);
      chk("R2 level_trig", level_trig, m_lt);
      chk("R2 single_mode", single_mode, m_sm);
      chk("R3 vec_base", vec_base, m_vb);
      chk("R4 casc_cfg", casc_cfg, m_casc);
      chk("R5 mode_flags", mode_flags, m_mode);
      chk("R5 ready", ready, (m_st == 4));
      chk((m_st == 4) ? "R7 irq_mask" : "R6 irq_mask", irq_mask, m_mask);
      chk("R9 ocw_valid", ocw_valid, m_ocwv);
      if (m_ocwv) chk("R9 ocw_data", ocw_data, m_ocwd);
      chk("R11 vec_out", vec_out, exp_vec(m_vb, irq_level));
   endtask

   // One cycle: drive at negedge, model update, check at the next negedge.
   task automatic op(bit w, logic [15:0] a, logic [7:0] d);
      io_wr = w; io_addr = a; io_wdata = d; irq_level = 3'($urandom);
      m_clr = 0; m_ocwv = 0;
      if (w && a == BASE) begin
         if (d[4]) begin
            m_st = 1; m_mask = 0; m_lt = d[3]; m_sm = d[1]; m_clr = 1;
         end else begin
            m_ocwv = 1; m_ocwd = d;
         end
      end else if (w && a == BASE + 16'd1) begin
         case (m_st)
            1: begin m_vb = d[7:3]; m_st = 2; end
            2: begin m_casc = d; m_st = 3; end
            3: begin m_mode = d[4:0]; m_st = 4; end
            4: m_mask = d;
            default: ;
         endcase
      end
      @(posedge clk);
      @(negedge clk);
      io_wr = 0;
      check_all();
   endtask

   initial begin : watchdog
      #400000;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin : stim
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      // R1: reset values
      chk("R1 ready", ready, 0);
      chk("R1 irq_mask", irq_mask, 0);
      chk("R1 vec_base", vec_base, 0);
      chk("R1 casc_cfg", casc_cfg, 0);
      chk("R1 mode_flags", mode_flags, 0);
      chk("R1 pulses", {init_clr, ocw_valid, level_trig, single_mode}, 0);
      rst_n = 1;
      @(negedge clk);

      // R6: mask writes before any init are ignored
      op(1, BASE + 1, 8'hA5);
      chk("R6 pre-init mask", irq_mask, 0);

      // Full sequence: start, words 2..4, then a mask write
      op(1, BASE, 8'h1A);
      op(1, BASE + 1, 8'hC8);
      chk("R6 mask held in seq", irq_mask, 0);
      op(1, BASE + 1, 8'h04);
      op(1, BASE + 1, 8'h1F);
      chk("R5 ready after word4", ready, 1);
      op(1, BASE + 1, 8'h3C);
      chk("R7 mask loaded", irq_mask, 8'h3C);

      // R9: command word mid-sequence does not disturb progress
      op(1, BASE, 8'h10);
      op(1, BASE + 1, 8'h40);
      op(1, BASE, 8'h0B);
      op(1, BASE + 1, 8'h77);
      chk("R9 seq kept casc", casc_cfg, 8'h77);

      // R8: restart mid-sequence goes back to word 2
      op(1, BASE, 8'h18);
      chk("R8 ready dropped", ready, 0);
      op(1, BASE + 1, 8'h98);
      chk("R8 restart vec_base", vec_base, 5'h13);

      // R10: foreign addresses and idle cycles
      op(1, 16'h00A0, 8'hFF);
      op(1, 16'h0022, 8'h55);
      op(0, BASE + 1, 8'hEE);
      chk("R10 foreign ignored casc", casc_cfg, 8'h77);
      op(1, BASE + 1, 8'h21);
      op(1, BASE + 1, 8'h0E);
      op(0, BASE, 8'h10);
      chk("R10 idle no start", ready, 1);

      // Random traffic
      for (int i = 0; i < 4000; i++) begin
         int unsigned r = $urandom_range(0, 99);
         logic [7:0]  d = 8'($urandom);
         if (r < 10)      op(0, BASE, d);
         else if (r < 22) op(1, BASE, d | 8'h10);
         else if (r < 35) op(1, BASE, d & 8'hEF);
         else if (r < 85) op(1, BASE + 1, d);
         else             op(1, 16'($urandom) & 16'h00FE ^ 16'h0080, d);
      end

      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule